// File: doc/BRIEF.md
# Supply and Watchdog Reset Supervisor

This block produces the system reset for a processor. It watches a digital supply-good flag, which comes from an analog comparator outside the block. It also runs a watchdog that the host keeps alive through its chip-select line. Reset is held through power-up and through any brownout. It is released only after the supply has stayed good without a break for a hold period. Reset is also raised when the host fails to pulse chip-select within the selected timeout.

All periods are counted in ticks of a timebase strobe. Parameters set the hold length and the three watchdog lengths, so a small configuration can stand in for the nominal millisecond values. A 2-bit code, normally read from a status register, chooses the watchdog length or turns the watchdog off. One parameter picks an active-low or an active-high reset level. A separate enable tells an open-drain pad when to pull the pin.

Top module: `supv_rst_wdog`

## Requirements
- R1: While `por_n` is low, reset is asserted (`rst_drive_en` = 1). When `por_n` rises, reset stays asserted until the hold qualification of R2 completes.
- R2: Reset is released after HOLD_TICKS tick strobes, counted while the supply flag is high without interruption and reset is asserted. The release takes effect on the clock edge of the last of those ticks.
- R3: When `supply_ok` is low, reset is asserted in the same cycle. Returning to high restarts the hold count from zero, so a drop partway through the hold demands a full HOLD_TICKS again.
- R4: A high-to-low transition of `cs_wdi`, seen between two clock edges, clears the watchdog count. Regular transitions therefore keep reset released.
- R5: With the watchdog enabled, if `cs_wdi` shows no falling edge for the selected number of ticks, reset is asserted on the edge of the last such tick. This holds whether the line rests high or low.
- R6: `wd_sel` encodes the timeout as follows: 2'b00 gives WD_LONG_TICKS, 2'b01 gives WD_MID_TICKS, 2'b10 gives WD_SHORT_TICKS, and 2'b11 disables the watchdog, so no watchdog reset ever occurs.
- R7: A watchdog reset is held for HOLD_TICKS ticks, then released. The watchdog count starts again from zero at the release.
- R8: While reset is asserted for any reason, the watchdog count is held at zero. The first watchdog timeout after a release therefore takes the full selected number of ticks.
- R9: Any change of `wd_sel` restarts the watchdog count from zero. The new timeout is then counted in full from the change.
- R10: With ACTIVE_HIGH = 0, `rst_out` is low while reset is asserted. With ACTIVE_HIGH = 1, it is high while reset is asserted. `rst_drive_en` is 1 exactly while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on clear, active low, sampled on the clock |
| tick | input | 1 | One-cycle timebase strobe |
| supply_ok | input | 1 | High while the supply is above the trip threshold |
| cs_wdi | input | 1 | Host chip-select, doubling as the watchdog input |
| wd_sel | input | 2 | Watchdog timeout code |
| rst_out | output | 1 | Reset level at the polarity chosen by ACTIVE_HIGH |
| rst_drive_en | output | 1 | Open-drain pull enable, high while reset is asserted |

## Verification
The assertions assume that `tick` is a single-cycle strobe. They also assume that `wd_sel`, `supply_ok` and `cs_wdi` are already synchronous to `clk`. The stimulus changes every input only on the falling clock edge, and keeps a tick away from the cycles in which the chip-select line moves. As a result, a kick never coincides with a count step. Hold and timeout lengths are measured by counting the strobes the stimulus issues up to the visible output change. A second instance with the opposite polarity is compared against the first throughout.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Timeout length in ticks for a watchdog code; zero when disabled
  function automatic int wd_limit(input logic [1:0] sel, input int t_long,
                                  input int t_mid, input int t_short);
    case (sel)
      2'b00:   return t_long;
      2'b01:   return t_mid;
      2'b10:   return t_short;
      default: return 0;
    endcase
  endfunction

  function automatic logic wd_on(input logic [1:0] sel);
    return sel != 2'b11;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/supv_cs_edge.sv
module supv_cs_edge (
  input  logic clk,
  input  logic por_n,
  input  logic cs_wdi,
  output logic cs_fall
);
  logic cs_q;

  always_ff @(posedge clk) begin
    if (!por_n) cs_q <= 1'b0;
    else        cs_q <= cs_wdi;
  end

  assign cs_fall = cs_q & ~cs_wdi;
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
  import supv_pkg::*;
#(
  parameter int WD_LONG_TICKS  = 1400,
  parameter int WD_MID_TICKS   = 600,
  parameter int WD_SHORT_TICKS = 200
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       cs_fall,
  input  logic [1:0] wd_sel,
  input  logic       hold_clr,
  output logic       wd_expire
);
  localparam int MAXT  = max3(WD_LONG_TICKS, WD_MID_TICKS, WD_SHORT_TICKS);
  localparam int CNT_W = $clog2(MAXT + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_m1;
  logic [1:0]       sel_q;
  logic             sel_chg;
  logic             restart;

  assign lim_m1  = CNT_W'(wd_limit(wd_sel, WD_LONG_TICKS, WD_MID_TICKS,
                                   WD_SHORT_TICKS) - 1);
  assign sel_chg = (wd_sel != sel_q);
  assign restart = hold_clr | cs_fall | sel_chg | ~wd_on(wd_sel);
  assign wd_expire = ~restart & tick & (cnt >= lim_m1);

  always_ff @(posedge clk) begin
    if (!por_n) begin
      sel_q <= 2'b11;
      cnt   <= '0;
    end else begin
      sel_q <= wd_sel;
      if (restart || wd_expire) cnt <= '0;
      else if (tick)            cnt <= cnt + 1'b1;
    end
  end

  AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    cs_fall |=> (cnt == '0)); // R4

  AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!por_n)
    hold_clr |=> (cnt == '0)); // R8

  AST_WD_OFF_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    (wd_sel == 2'b11) |=> (cnt == '0)); // R6

  AST_WD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!por_n)
    (wd_on(wd_sel) && !sel_chg) |-> (cnt <= lim_m1)); // R9
endmodule

// File: rtl/supv_hold.sv
module supv_hold #(
  parameter int HOLD_TICKS = 200
) (
  input  logic clk,
  input  logic por_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic wd_expire,
  output logic rst_q
);
  localparam int HCNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [HCNT_W-1:0] HOLD_LAST = HCNT_W'(HOLD_TICKS - 1);

  logic [HCNT_W-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (!por_n || !supply_ok || wd_expire) begin
      rst_q <= 1'b1;
      hcnt  <= '0;
    end else if (rst_q && tick) begin
      if (hcnt >= HOLD_LAST) begin
        rst_q <= 1'b0;
        hcnt  <= '0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  AST_RELEASE_QUALIFIED: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_q) |-> ($past(supply_ok) && $past(tick))); // R2

  AST_BROWNOUT_RESTART: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> (rst_q && hcnt == '0)); // R3
endmodule

// File: rtl/supv_rst_wdog.sv
module supv_rst_wdog #(
  parameter int HOLD_TICKS     = 200,
  parameter int WD_LONG_TICKS  = 1400,
  parameter int WD_MID_TICKS   = 600,
  parameter int WD_SHORT_TICKS = 200,
  parameter bit ACTIVE_HIGH    = 1'b0
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       supply_ok,
  input  logic       cs_wdi,
  input  logic [1:0] wd_sel,
  output logic       rst_out,
  output logic       rst_drive_en
);
  logic cs_fall;
  logic wd_expire;
  logic rst_q;
  logic rst_asserted;

  supv_cs_edge u_edge (
    .clk     (clk),
    .por_n   (por_n),
    .cs_wdi  (cs_wdi),
    .cs_fall (cs_fall)
  );

  supv_wdog #(
    .WD_LONG_TICKS  (WD_LONG_TICKS),
    .WD_MID_TICKS   (WD_MID_TICKS),
    .WD_SHORT_TICKS (WD_SHORT_TICKS)
  ) u_wdog (
    .clk       (clk),
    .por_n     (por_n),
    .tick      (tick),
    .cs_fall   (cs_fall),
    .wd_sel    (wd_sel),
    .hold_clr  (rst_asserted),
    .wd_expire (wd_expire)
  );

  supv_hold #(
    .HOLD_TICKS (HOLD_TICKS)
  ) u_hold (
    .clk       (clk),
    .por_n     (por_n),
    .tick      (tick),
    .supply_ok (supply_ok),
    .wd_expire (wd_expire),
    .rst_q     (rst_q)
  );

  // Supply loss bypasses the register so reset follows it without delay
  assign rst_asserted = rst_q | ~supply_ok | ~por_n;
  assign rst_drive_en = rst_asserted;

  generate
    if (ACTIVE_HIGH) begin : g_hi
      assign rst_out = rst_asserted;
    end else begin : g_lo
      assign rst_out = ~rst_asserted;
    end
  endgenerate

  AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |=> rst_drive_en); // R7

  AST_SUPPLY_LOW_RESET: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |-> rst_drive_en); // R3
endmodule

// File: tb/sim_supv_rst_wdog.sv
module sim_supv_rst_wdog;
  localparam int HOLD = 5;
  localparam int TL   = 14;
  localparam int TM   = 6;
  localparam int TS   = 3;

  logic clk = 1'b0;
  logic por_n, tick, supply_ok, cs_wdi;
  logic [1:0] wd_sel;
  logic rst_lo, en_lo, rst_hi, en_hi;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  supv_rst_wdog #(.HOLD_TICKS(HOLD), .WD_LONG_TICKS(TL), .WD_MID_TICKS(TM),
                  .WD_SHORT_TICKS(TS), .ACTIVE_HIGH(1'b0)) u0 (
    .clk(clk), .por_n(por_n), .tick(tick), .supply_ok(supply_ok),
    .cs_wdi(cs_wdi), .wd_sel(wd_sel), .rst_out(rst_lo), .rst_drive_en(en_lo));

  supv_rst_wdog #(.HOLD_TICKS(HOLD), .WD_LONG_TICKS(TL), .WD_MID_TICKS(TM),
                  .WD_SHORT_TICKS(TS), .ACTIVE_HIGH(1'b1)) u1 (
    .clk(clk), .por_n(por_n), .tick(tick), .supply_ok(supply_ok),
    .cs_wdi(cs_wdi), .wd_sel(wd_sel), .rst_out(rst_hi), .rst_drive_en(en_hi));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One strobe, then two quiet cycles; returns at a falling edge
  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    idle(2);
  endtask

  task automatic ticks_to_release(output int n);
    n = 0;
    while (en_lo && n < 100) begin
      do_tick();
      n++;
    end
  endtask

  task automatic ticks_to_assert(output int n);
    n = 0;
    while (!en_lo && n < 100) begin
      do_tick();
      n++;
    end
  endtask

  task automatic kick();
    cs_wdi = 1'b1;
    @(negedge clk);
    cs_wdi = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // Polarity cross-check on every falling edge
  int pol_bad = 0;
  always @(negedge clk) begin
    if (rst_lo != ~en_lo || rst_hi != en_hi || en_hi != en_lo) pol_bad++;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0 (run hung)");
      summary();
    end
  end

  initial begin
    int n;
    int hits;
    por_n = 1'b0; tick = 1'b0; supply_ok = 1'b1; cs_wdi = 1'b1; wd_sel = 2'b11;
    idle(3);
    do_tick();
    chk("R1 reset during por_n low", en_lo, 1);
    chk("R10 active-low level in reset", rst_lo, 0);
    chk("R10 active-high level in reset", rst_hi, 1);
    por_n = 1'b1;
    idle(2);
    chk("R1 still asserted after por_n rise", en_lo, 1);

    ticks_to_release(n);
    chk("R2 hold ticks at power-up", n, HOLD);
    chk("R10 active-low released level", rst_lo, 1);
    chk("R10 active-high released level", rst_hi, 0);

    // Disabled code: long quiet period without any reset
    hits = 0;
    for (int i = 0; i < 40; i++) begin
      do_tick();
      if (en_lo) hits++;
    end
    chk("R6 code 11 never resets", hits, 0);

    // Short timeout, line resting high
    wd_sel = 2'b10;
    idle(1);
    ticks_to_assert(n);
    chk("R5 short timeout, cs high", n, TS);
    cs_wdi = 1'b0;
    idle(1);
    ticks_to_release(n);
    chk("R7 watchdog reset hold", n, HOLD);
    ticks_to_assert(n);
    chk("R5 short timeout, cs low, R7 restart", n, TS);
    ticks_to_release(n);
    chk("R7 second hold", n, HOLD);

    // Kicks keep reset away
    hits = 0;
    for (int i = 0; i < 10; i++) begin
      do_tick();
      do_tick();
      kick();
      if (en_lo) hits++;
    end
    chk("R4 kicks prevent reset", hits, 0);
    ticks_to_assert(n);
    chk("R4 timeout counted from last kick", n, TS);
    ticks_to_release(n);

    wd_sel = 2'b01;
    idle(1);
    ticks_to_assert(n);
    chk("R6 code 01 length", n, TM);
    ticks_to_release(n);
    wd_sel = 2'b00;
    idle(1);
    ticks_to_assert(n);
    chk("R6 code 00 length", n, TL);
    ticks_to_release(n);

    // Code change restarts the count
    wd_sel = 2'b01;
    idle(1);
    for (int i = 0; i < 4; i++) do_tick();
    chk("R9 no reset before change", en_lo, 0);
    wd_sel = 2'b10;
    idle(1);
    ticks_to_assert(n);
    chk("R9 full short timeout after change", n, TS);
    ticks_to_release(n);

    // Brownout
    wd_sel = 2'b11;
    idle(1);
    supply_ok = 1'b0;
    #1;
    chk("R3 immediate assert on supply loss", en_lo, 1);
    chk("R10 active-high follows supply loss", rst_hi, 1);
    idle(1);
    for (int i = 0; i < 3; i++) do_tick();
    supply_ok = 1'b1;
    idle(1);
    for (int i = 0; i < 3; i++) do_tick();
    chk("R3 not released mid-hold", en_lo, 1);
    supply_ok = 1'b0;
    idle(1);
    supply_ok = 1'b1;
    idle(1);
    ticks_to_release(n);
    chk("R3 hold restarts after drop", n, HOLD);

    // Watchdog held cleared across a long supply reset
    wd_sel = 2'b10;
    supply_ok = 1'b0;
    idle(1);
    for (int i = 0; i < 10; i++) do_tick();
    supply_ok = 1'b1;
    idle(1);
    ticks_to_release(n);
    chk("R8 hold after brownout", n, HOLD);
    ticks_to_assert(n);
    chk("R8 full timeout after supply reset", n, TS);

    chk("R10 polarity mismatches", pol_bad, 0);
    done = 1'b1;
    summary();
  end
endmodule